// File: doc/BRIEF.md
# Slotted Backoff Countdown Timer

This block is the deferral timer of a wireless transmitter that shares its medium with other stations. Software loads a slot count and pulses a start input. The timer first waits until the medium has been idle for one full inter-frame interval. It then counts whole slot periods down to zero and emits a one-cycle completion pulse. If the medium turns busy, the timer drops any partial interval or slot and waits for a fresh idle inter-frame interval before it counts again. The remaining slot count is visible on an output at all times.

All durations are given in 100 ns units. A parameterised prescaler derives these units from the system clock. The prescaler restarts whenever the timing restarts, so one unit is always exactly `TICK_DIV` idle, unpaused clock cycles. A select input chooses an extended inter-frame interval in place of the normal one, which is used after an errored reception. A synchronous clear input aborts the timer. A pause input freezes all progress while it is high.

Top module: `slot_backoff_timer`

## Requirements
- R1: After reset, `remaining` is 0 and both `active` and `done` are 0.
- R2: A `start` sampled at a clock edge loads `load_cnt` into `remaining` and sets `active` at that edge. If `clr` is high at the same edge, `clr` wins.
- R3: With the medium idle and no pause, `done` rises at the edge that is (N + K·S)·`TICK_DIV` edges after the start edge. N is the inter-frame interval, K is the loaded count and S is the slot length. `remaining` decreases by exactly one at the edge that closes each slot.
- R4: A start with a loaded count of 0 completes after the inter-frame interval alone, at N·`TICK_DIV` edges.
- R5: A busy medium during the inter-frame wait restarts that wait. Completion then takes the full N + K·S units counted from the last busy edge.
- R6: A busy medium during a slot discards the partial slot and leaves `remaining` unchanged. A new full inter-frame interval must pass before slots resume.
- R7: While `pause` is high there is no progress: `remaining` holds and `done` stays low. Each paused edge delays completion by one edge.
- R8: `clr` sets `remaining` to 0 and `active` to 0 at the next edge, and no `done` follows.
- R9: When `use_ext_ifs` is 1, the 16-bit `ext_ifs_len` replaces `ifs_len` as the inter-frame interval.
- R10: `done` is high for exactly one cycle, and `active` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slot_len | input | 10 | Slot duration in 100 ns units |
| ifs_len | input | 10 | Normal inter-frame interval in 100 ns units |
| ext_ifs_len | input | 16 | Extended inter-frame interval in 100 ns units |
| use_ext_ifs | input | 1 | Selects the extended interval |
| medium_busy | input | 1 | Medium is busy |
| load_cnt | input | 16 | Slot count loaded on start |
| start | input | 1 | Load the count and begin deferral |
| clr | input | 1 | Clear the count and abort |
| pause | input | 1 | Freeze all progress |
| remaining | output | 16 | Slots still to count |
| active | output | 1 | Deferral in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench measures the exact edge at which completion occurs in three situations: an idle medium, a zero count and the extended interval. A prescaler or unit counter that is off by one would move this edge by a full unit or by a cycle. It places busy periods both inside the inter-frame wait and in the middle of a slot. A design that resumes a half-finished slot, decrements on busy, or skips the new inter-frame wait would finish early or show the wrong count. It also covers pause, a clear that races with start, and the width of the completion pulse. A design that leaks progress through pause, or that pulses again after a clear, fails on completion time or on a spurious `done`.

// File: rtl/bkoff_pkg.sv
package bkoff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEFER = 2'd1,
    ST_SLOT  = 2'd2
  } bk_state_t;
endpackage

// File: rtl/bkoff_prescale.sv
// Divides the clock into 100 ns units; restarts on clear.
module bkoff_prescale #(
  parameter int TICK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && !clear && (cnt_q == LAST);
  assign cnt_en = clear || run;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bkoff_unit_cnt.sv
// Counts units up to a target; flags the unit that completes it.
module bkoff_unit_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   cnt_inc;
  logic         cnt_en;

  assign cnt_inc = {1'b0, cnt_q} + (W+1)'(1);
  assign expire  = tick && !clear && (cnt_inc >= {1'b0, target});
  assign cnt_en  = clear || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)       cnt_d = '0;
    else if (expire) cnt_d = '0;
    else if (tick)   cnt_d = cnt_inc[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/slot_backoff_timer.sv
module slot_backoff_timer #(
  parameter int TICK_DIV = 10,
  parameter int CNT_W    = 16,
  parameter int DUR_W    = 10,
  parameter int EXT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DUR_W-1:0] slot_len,
  input  logic [DUR_W-1:0] ifs_len,
  input  logic [EXT_W-1:0] ext_ifs_len,
  input  logic             use_ext_ifs,
  input  logic             medium_busy,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             start,
  input  logic             clr,
  input  logic             pause,
  output logic [CNT_W-1:0] remaining,
  output logic             active,
  output logic             done
);
  import bkoff_pkg::*;

  localparam int TGT_W = (EXT_W > DUR_W) ? EXT_W : DUR_W;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  bk_state_t        state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             done_q, done_d;
  logic             run, restart, tick, expire;
  logic [TGT_W-1:0] target;

  assign active  = (state_q != ST_IDLE);
  assign run     = active && !pause && !medium_busy;
  assign restart = start || clr || (active && medium_busy);

  always_comb begin
    if (state_q == ST_SLOT)  target = TGT_W'(slot_len);
    else if (use_ext_ifs)    target = TGT_W'(ext_ifs_len);
    else                     target = TGT_W'(ifs_len);
  end

  bkoff_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_i), .run(run), .clear(restart), .tick(tick)
  );

  bkoff_unit_cnt #(.W(TGT_W)) u_unit (
    .clk(clk), .rst_n(rst_i), .clear(restart), .tick(tick),
    .target(target), .expire(expire)
  );

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    if (clr) begin
      state_d = ST_IDLE;
      rem_d   = '0;
    end else if (start) begin
      state_d = ST_DEFER;
      rem_d   = load_cnt;
    end else if (active && medium_busy) begin
      state_d = ST_DEFER;
    end else if (expire) begin
      if (state_q == ST_DEFER) begin
        if (rem_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_SLOT;
        end
      end else if (state_q == ST_SLOT) begin
        rem_d = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  assign remaining = rem_q;
  assign done      = done_q;
endmodule

// File: rtl/bkoff_checker.sv
module bkoff_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             clr,
  input logic             pause,
  input logic             medium_busy,
  input logic [CNT_W-1:0] load_cnt,
  input logic [CNT_W-1:0] remaining,
  input logic             active,
  input logic             done
);
  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr) |=> (active && remaining == $past(load_cnt)));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && !clr) |=>
      (remaining == $past(remaining) || remaining == $past(remaining) - CNT_W'(1)));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (medium_busy && !start && !clr) |=> ($stable(remaining) && !done));

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !start && !clr) |=> ($stable(remaining) && !done));

  assert_clr_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (remaining == '0 && !active && !done));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
endmodule

bind slot_backoff_timer bkoff_checker #(.CNT_W(CNT_W)) u_bkoff_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .pause(pause),
  .medium_busy(medium_busy), .load_cnt(load_cnt), .remaining(remaining),
  .active(active), .done(done)
);

// File: tb/sim_slot_backoff_timer.sv
module sim_slot_backoff_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 5;
  localparam int WATCHDOG   = 100000;

  logic        clk, rst_n;
  logic [9:0]  slot_len, ifs_len;
  logic [15:0] ext_ifs_len, load_cnt, remaining;
  logic        use_ext_ifs, medium_busy, start, clr, pause, active, done;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  slot_backoff_timer #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_len(slot_len), .ifs_len(ifs_len),
    .ext_ifs_len(ext_ifs_len), .use_ext_ifs(use_ext_ifs),
    .medium_busy(medium_busy), .load_cnt(load_cnt), .start(start),
    .clr(clr), .pause(pause), .remaining(remaining), .active(active),
    .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // advance n edges, ending just after a falling edge
  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // drive start; returns just after the start edge
  task automatic kick(input logic [15:0] n);
    @(negedge clk);
    load_cnt = n;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // edge index (after the reference edge) at which done is first seen
  task automatic wait_done(input int limit, output int idx);
    idx = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (done === 1'b1) begin
        idx = i;
        break;
      end
    end
  endtask

  task automatic t_reset;
    chk("R1 remaining", 32'(remaining), 0);
    chk("R1 active", 32'(active), 0);
    chk("R1 done", 32'(done), 0);
  endtask

  task automatic t_load;
    ifs_len = 10'd3; slot_len = 10'd2;
    kick(16'h1234);
    chk("R2 loaded count", 32'(remaining), 32'h1234);
    chk("R2 active", 32'(active), 1);
    @(negedge clk);
    load_cnt = 16'd9; start = 1'b1; clr = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0; clr = 1'b0;
    chk("R2 clr beats start count", 32'(remaining), 0);
    chk("R2 clr beats start active", 32'(active), 0);
  endtask

  task automatic t_idle;
    int idx;
    ifs_len = 10'd3; slot_len = 10'd2;
    kick(16'd3);
    wait_done(200, idx);
    chk("R3 idle completion edge", 32'(idx), 32'((3 + 3*2) * DIV));
    chk("R10 inactive with done", 32'(active), 0);
    @(posedge clk); @(negedge clk);
    chk("R10 done one cycle", 32'(done), 0);
  endtask

  task automatic t_zero;
    int idx;
    ifs_len = 10'd4; slot_len = 10'd2;
    kick(16'd0);
    wait_done(200, idx);
    chk("R4 zero count edge", 32'(idx), 32'(4 * DIV));
  endtask

  task automatic t_busy_defer;
    int idx;
    ifs_len = 10'd3; slot_len = 10'd2;
    kick(16'd2);
    edges(10);
    medium_busy = 1'b1;
    edges(4);
    medium_busy = 1'b0;
    chk("R5 count kept", 32'(remaining), 2);
    wait_done(200, idx);
    chk("R5 restart from last busy", 32'(idx), 32'((3 + 2*2) * DIV));
  endtask

  task automatic t_busy_slot;
    int idx;
    ifs_len = 10'd2; slot_len = 10'd4;
    kick(16'd3);
    edges(29);
    chk("R3 before first slot end", 32'(remaining), 3);
    edges(1);
    chk("R3 after first slot end", 32'(remaining), 2);
    edges(12);
    medium_busy = 1'b1;
    edges(3);
    medium_busy = 1'b0;
    chk("R6 partial slot not counted", 32'(remaining), 2);
    wait_done(300, idx);
    chk("R6 fresh interval then slots", 32'(idx), 32'((2 + 2*4) * DIV));
  endtask

  task automatic t_pause;
    int idx;
    ifs_len = 10'd2; slot_len = 10'd2;
    kick(16'd1);
    edges(7);
    pause = 1'b1;
    edges(6);
    chk("R7 count held", 32'(remaining), 1);
    chk("R7 still active", 32'(active), 1);
    pause = 1'b0;
    wait_done(200, idx);
    chk("R7 delayed by pause", 32'(idx), 32'((2 + 2) * DIV - 7));
  endtask

  task automatic t_clear;
    int idx;
    ifs_len = 10'd2; slot_len = 10'd2;
    kick(16'd5);
    edges(15);
    clr = 1'b1;
    edges(1);
    clr = 1'b0;
    chk("R8 count cleared", 32'(remaining), 0);
    chk("R8 inactive", 32'(active), 0);
    wait_done(100, idx);
    chk("R8 no done after clear", 32'(idx), 32'hFFFF_FFFF);
  endtask

  task automatic t_ext;
    int idx;
    ifs_len = 10'd2; slot_len = 10'd2; ext_ifs_len = 16'd7;
    use_ext_ifs = 1'b1;
    kick(16'd1);
    wait_done(200, idx);
    chk("R9 extended interval", 32'(idx), 32'((7 + 2) * DIV));
    use_ext_ifs = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    slot_len = '0; ifs_len = '0; ext_ifs_len = '0; use_ext_ifs = 1'b0;
    medium_busy = 1'b0; load_cnt = '0; start = 1'b0; clr = 1'b0; pause = 1'b0;
    edges(3);
    t_reset();
    rst_n = 1'b1;
    edges(4);
    t_reset();
    t_load();
    t_idle();
    t_zero();
    t_busy_defer();
    t_busy_slot();
    t_pause();
    t_clear();
    t_ext();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule